// File: doc/BRIEF.md
# Multi-Domain Reset Generator

This block produces every reset used by a fieldbus slave node whose logic runs in three clock domains: a user clock, a bus-interface clock and a transmit clock. It merges four kinds of request: an active-low power-on reset, a user reset input, a bus-side reset input, and two single-cycle pulses from a frame decoder. One pulse reports a valid reset frame addressed to the node. The other reports a valid reset frame addressed to the attached user equipment. Frame decoding and address matching happen elsewhere. The two decoder pulses and the user reset input belong to the user clock domain.

The power-on reset takes hold at once in every domain, without waiting for a clock edge. In each domain its release passes through a two-stage shift chain clocked by that domain's clock. The user reset input is synchronized and then qualified by a minimum hold time before it can act. Each accepted source starts a fixed-length pulse. Where a pulse belongs to another clock domain, it is handed across with a toggle. The length is then counted entirely in the destination clock.

A static mode select chooses how the reset inputs split across the domains. In memory mode the bus reset input drives the bus domain and the user reset input drives the user domain, each on its own. In stand-alone mode the bus is unused. The internal user-domain pulse then also clears the bus domain, and the bus reset input is ignored.

Top module: `node_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_user`, `rst_bus` and `rst_xcvr` are high without any clock edge. After `por_n` rises, `rst_user` and `rst_xcvr` fall on the second rising `uclk` edge, and `rst_bus` falls on the second rising `wclk` edge.
- R2: The power-on reset never asserts `rst_ext`, which is low during and after it.
- R3: `usr_rst_in` (active high), after a two-stage synchronizer, is accepted only once it has been high on 4 consecutive `uclk` edges. A shorter assertion produces no reset on any output.
- R4: An accepted user reset drives `rst_user` high for exactly 4 `uclk` cycles. An input held high for a long time gives one pulse only. A new pulse needs the input to go low and then be qualified again.
- R5: A one-cycle `node_hit` pulse drives `rst_user` high for exactly 4 `uclk` cycles.
- R6: An accepted user reset or a `node_hit` pulse drives `rst_xcvr` high for exactly 4 `tclk` cycles.
- R7: A one-cycle `user_hit` pulse drives `rst_ext` high for exactly 8 `uclk` cycles and leaves `rst_user` low.
- R8: In memory mode (`standalone` = 0), `rst_bus` goes high at the first rising `wclk` edge after `bus_rst_in` rises, and falls at the first rising edge after it falls. `bus_rst_in` leaves `rst_user` low, and an accepted user reset leaves `rst_bus` low.
- R9: In stand-alone mode (`standalone` = 1), `bus_rst_in` has no effect on `rst_bus`, and an accepted user reset also drives `rst_bus` high.
- R10: A new trigger that arrives while a pulse is running restarts its count. Two `node_hit` pulses two cycles apart keep `rst_user` high for 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uclk | input | 1 | User clock |
| wclk | input | 1 | Bus-interface clock |
| tclk | input | 1 | Transmit clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| usr_rst_in | input | 1 | User reset request, active high, `uclk` domain |
| bus_rst_in | input | 1 | Bus reset request, active high, `wclk` domain |
| standalone | input | 1 | Mode select: 0 memory, 1 stand-alone (static) |
| node_hit | input | 1 | Valid reset frame addressed to the node, one `uclk` cycle |
| user_hit | input | 1 | Valid reset frame addressed to the user, one `uclk` cycle |
| rst_user | output | 1 | Internal user-domain reset |
| rst_bus | output | 1 | Bus-domain reset |
| rst_xcvr | output | 1 | Transceiver reset |
| rst_ext | output | 1 | External user reset |

## Verification
The user reset input is driven for 3, 4 and 20 cycles, and then driven again after release. The 3/4 pair fixes the qualification threshold exactly, and the long hold shows that a held input yields one pulse only. Single `node_hit` and `user_hit` pulses tell the node-targeted path apart from the user-targeted one, since each must light one output and leave the other dark. Back-to-back node hits separate a restarted count from one that ends early. Driving the bus reset and the user reset in both modes shows which domain each input reaches.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    typedef enum logic {
        MODE_MEMORY     = 1'b0,
        MODE_STANDALONE = 1'b1
    } mode_e;

    typedef struct packed {
        logic user;
        logic bus;
        logic xcvr;
        logic ext;
    } rst_bundle_t;

    localparam int SYNC_STAGES = 2;
    localparam int USR_HOLD    = 4;
    localparam int NODE_LEN    = 4;
    localparam int XCVR_LEN    = 4;
    localparam int EXT_LEN     = 8;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rg_por_sync.sv
module rg_por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    output logic rst
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign rst = chain[STAGES-1];
endmodule

// File: rtl/rg_bit_sync.sv
module rg_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rg_hold_filter.sv
module rg_hold_filter
    import rstgen_pkg::*;
#(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic accept
);
    localparam int W = cnt_w(HOLD);
    localparam logic [W-1:0] LAST = W'(HOLD - 1);

    logic [W-1:0] run;
    logic         fired;

    assign accept = din && (run == LAST) && !fired;

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= '0;
            fired <= 1'b0;
        end else if (!din) begin
            run   <= '0;
            fired <= 1'b0;
        end else begin
            if (run != LAST) run <= run + 1'b1;
            if (accept)      fired <= 1'b1;
        end
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept); // R4
    AST_DROP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        !din |=> !accept); // R3
endmodule

// File: rtl/rg_stretch.sv
module rg_stretch
    import rstgen_pkg::*;
#(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic busy
);
    localparam int W = cnt_w(LEN);

    logic [W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)              left <= '0;
        else if (trig)        left <= W'(LEN);
        else if (left != '0)  left <= left - 1'b1;
    end

    assign busy = (left != '0);

    AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (rst)
        trig |=> busy); // R5
    AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(trig)); // R10
endmodule

// File: rtl/rg_toggle_xfer.sv
module rg_toggle_xfer
    import rstgen_pkg::*;
#(
    parameter int LEN    = 4,
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic trig,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic busy
);
    logic tog;
    logic tog_s;
    logic tog_d;
    logic flip;

    always_ff @(posedge src_clk) begin
        if (src_rst)   tog <= 1'b0;
        else if (trig) tog <= ~tog;
    end

    rg_bit_sync #(.STAGES(STAGES)) u_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (tog),
        .q   (tog_s)
    );

    always_ff @(posedge dst_clk) begin
        if (dst_rst) tog_d <= 1'b0;
        else         tog_d <= tog_s;
    end

    assign flip = tog_s ^ tog_d;

    rg_stretch #(.LEN(LEN)) u_len (
        .clk  (dst_clk),
        .rst  (dst_rst),
        .trig (flip),
        .busy (busy)
    );

    AST_TX_ONLY_ON_FLIP: assert property (@(posedge dst_clk) disable iff (dst_rst)
        $rose(busy) |-> $past(flip)); // R6
endmodule

// File: rtl/node_reset_gen.sv
module node_reset_gen
    import rstgen_pkg::*;
(
    input  logic uclk,
    input  logic wclk,
    input  logic tclk,
    input  logic por_n,
    input  logic usr_rst_in,
    input  logic bus_rst_in,
    input  logic standalone,
    input  logic node_hit,
    input  logic user_hit,
    output logic rst_user,
    output logic rst_bus,
    output logic rst_xcvr,
    output logic rst_ext
);
    mode_e       mode;
    rst_bundle_t outs;

    logic por_u, por_w, por_t;
    logic usr_s, usr_ok, node_trig;
    logic node_busy, ext_busy, tx_busy;
    logic bus_q, sa_busy_w;

    assign mode = mode_e'(standalone);

    rg_por_sync #(.STAGES(SYNC_STAGES)) u_por_u (.clk(uclk), .por_n(por_n), .rst(por_u));
    rg_por_sync #(.STAGES(SYNC_STAGES)) u_por_w (.clk(wclk), .por_n(por_n), .rst(por_w));
    rg_por_sync #(.STAGES(SYNC_STAGES)) u_por_t (.clk(tclk), .por_n(por_n), .rst(por_t));

    rg_bit_sync #(.STAGES(SYNC_STAGES)) u_usr_sync (
        .clk (uclk), .rst (por_u), .d (usr_rst_in), .q (usr_s)
    );

    rg_hold_filter #(.HOLD(USR_HOLD)) u_hold (
        .clk (uclk), .rst (por_u), .din (usr_s), .accept (usr_ok)
    );

    assign node_trig = usr_ok | node_hit;

    rg_stretch #(.LEN(NODE_LEN)) u_node (
        .clk (uclk), .rst (por_u), .trig (node_trig), .busy (node_busy)
    );

    rg_stretch #(.LEN(EXT_LEN)) u_ext (
        .clk (uclk), .rst (por_u), .trig (user_hit), .busy (ext_busy)
    );

    rg_toggle_xfer #(.LEN(XCVR_LEN), .STAGES(SYNC_STAGES)) u_tx (
        .src_clk (uclk), .src_rst (por_u), .trig (node_trig),
        .dst_clk (tclk), .dst_rst (por_t), .busy (tx_busy)
    );

    always_ff @(posedge wclk) begin
        if (por_w) bus_q <= 1'b0;
        else       bus_q <= bus_rst_in && (mode == MODE_MEMORY);
    end

    rg_bit_sync #(.STAGES(SYNC_STAGES)) u_sa_sync (
        .clk (wclk), .rst (por_w), .d (node_busy), .q (sa_busy_w)
    );

    always_comb begin
        outs.user = por_u | node_busy;
        outs.bus  = por_w | bus_q | (sa_busy_w && (mode == MODE_STANDALONE));
        outs.xcvr = por_u | tx_busy;
        outs.ext  = ext_busy;
    end

    assign rst_user = outs.user;
    assign rst_bus  = outs.bus;
    assign rst_xcvr = outs.xcvr;
    assign rst_ext  = outs.ext;

    AST_EXT_FROM_FRAME: assert property (@(posedge uclk) disable iff (por_u)
        $rose(rst_ext) |-> $past(user_hit)); // R7
    AST_BUS_FOLLOWS: assert property (@(posedge wclk) disable iff (por_w)
        (!$past(por_w) && !standalone && $past(bus_rst_in)) |-> rst_bus); // R8
    AST_SA_BUS_QUIET: assert property (@(posedge wclk) disable iff (por_w)
        (standalone && $past(standalone) && !$past(por_w) && !sa_busy_w) |-> !rst_bus); // R9
endmodule

// File: tb/node_reset_gen_test.sv
module node_reset_gen_test;
    logic uclk = 1'b0, wclk = 1'b0, tclk = 1'b0;
    logic por_n = 1'b0, usr_rst_in = 1'b0, bus_rst_in = 1'b0;
    logic standalone = 1'b0, node_hit = 1'b0, user_hit = 1'b0;
    logic rst_user, rst_bus, rst_xcvr, rst_ext;

    int checks = 0;
    int fails  = 0;

    always #2.5 uclk = ~uclk;
    always #3.5 wclk = ~wclk;
    always #6   tclk = ~tclk;

    node_reset_gen uut (
        .uclk(uclk), .wclk(wclk), .tclk(tclk), .por_n(por_n),
        .usr_rst_in(usr_rst_in), .bus_rst_in(bus_rst_in), .standalone(standalone),
        .node_hit(node_hit), .user_hit(user_hit),
        .rst_user(rst_user), .rst_bus(rst_bus), .rst_xcvr(rst_xcvr), .rst_ext(rst_ext)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cnt_u(input int n, output int c);
        c = 0;
        repeat (n) begin @(negedge uclk); if (rst_user) c++; end
    endtask

    task automatic cnt_e(input int n, output int c);
        c = 0;
        repeat (n) begin @(negedge uclk); if (rst_ext) c++; end
    endtask

    task automatic cnt_t(input int n, output int c);
        c = 0;
        repeat (n) begin @(negedge tclk); if (rst_xcvr) c++; end
    endtask

    task automatic cnt_w(input int n, output int c);
        c = 0;
        repeat (n) begin @(negedge wclk); if (rst_bus) c++; end
    endtask

    task automatic hold_usr(input int n);
        @(negedge uclk) usr_rst_in = 1'b1;
        repeat (n) @(negedge uclk);
        usr_rst_in = 1'b0;
    endtask

    task automatic hit_node();
        @(negedge uclk) node_hit = 1'b1;
        @(negedge uclk) node_hit = 1'b0;
    endtask

    task automatic hit_user();
        @(negedge uclk) user_hit = 1'b1;
        @(negedge uclk) user_hit = 1'b0;
    endtask

    task automatic settle();
        repeat (20) @(negedge uclk);
    endtask

    task automatic t_power_on();
        #40;
        chk("R1 user in POR", rst_user, 1);
        chk("R1 bus in POR", rst_bus, 1);
        chk("R1 xcvr in POR", rst_xcvr, 1);
        chk("R2 ext in POR", rst_ext, 0);
        @(negedge uclk) por_n = 1'b1;
        fork
            begin
                @(negedge uclk);
                chk("R1 user after 1 edge", rst_user, 1);
                chk("R1 xcvr after 1 edge", rst_xcvr, 1);
                @(negedge uclk);
                chk("R1 user after 2 edges", rst_user, 0);
                chk("R1 xcvr after 2 edges", rst_xcvr, 0);
            end
            begin
                @(posedge wclk); @(negedge wclk);
                chk("R1 bus after 1 edge", rst_bus, 1);
                @(posedge wclk); @(negedge wclk);
                chk("R1 bus after 2 edges", rst_bus, 0);
            end
        join
        settle();
    endtask

    task automatic t_short_hold();
        int cu, ct;
        fork hold_usr(3); cnt_u(30, cu); cnt_t(20, ct); join
        chk("R3 3-cycle hold user", cu, 0);
        chk("R3 3-cycle hold xcvr", ct, 0);
        settle();
    endtask

    task automatic t_exact_hold();
        int cu, ct;
        fork hold_usr(4); cnt_u(30, cu); cnt_t(20, ct); join
        chk("R4 4-cycle hold user width", cu, 4);
        chk("R6 user reset xcvr width", ct, 4);
        settle();
    endtask

    task automatic t_long_hold();
        int cu;
        fork hold_usr(20); cnt_u(40, cu); join
        chk("R4 long hold single pulse", cu, 4);
        fork begin hold_usr(20); hold_usr(5); end cnt_u(60, cu); join
        chk("R4 re-accept after release", cu, 8);
        settle();
    endtask

    task automatic t_node_hit();
        int cu, ct, ce;
        fork hit_node(); cnt_u(20, cu); cnt_t(20, ct); cnt_e(20, ce); join
        chk("R5 node hit user width", cu, 4);
        chk("R6 node hit xcvr width", ct, 4);
        chk("R5 node hit ext quiet", ce, 0);
        settle();
    endtask

    task automatic t_user_hit();
        int cu, ce, ct;
        fork hit_user(); cnt_e(20, ce); cnt_u(20, cu); cnt_t(10, ct); join
        chk("R7 ext width", ce, 8);
        chk("R7 user stays low", cu, 0);
        chk("R7 xcvr stays low", ct, 0);
        settle();
    endtask

    task automatic t_retrigger();
        int cu;
        fork begin hit_node(); hit_node(); end cnt_u(25, cu); join
        chk("R10 restarted pulse width", cu, 6);
        settle();
    endtask

    task automatic t_memory_bus();
        int cw, cu;
        @(negedge wclk) bus_rst_in = 1'b1;
        #1 chk("R8 bus before edge", rst_bus, 0);
        @(negedge wclk);
        chk("R8 bus after edge", rst_bus, 1);
        chk("R8 user untouched by bus", rst_user, 0);
        bus_rst_in = 1'b0;
        #1 chk("R8 bus held until edge", rst_bus, 1);
        @(negedge wclk);
        chk("R8 bus released", rst_bus, 0);
        fork hold_usr(6); cnt_w(30, cw); cnt_u(30, cu); join
        chk("R8 user reset leaves bus", cw, 0);
        chk("R8 user reset still acts", cu, 4);
        settle();
    endtask

    task automatic t_standalone();
        int cw, cu;
        standalone = 1'b1;
        settle();
        fork
            begin @(negedge wclk) bus_rst_in = 1'b1; repeat (10) @(negedge wclk); bus_rst_in = 1'b0; end
            cnt_w(15, cw);
        join
        chk("R9 bus input ignored", cw, 0);
        fork hold_usr(6); cnt_w(30, cw); cnt_u(30, cu); join
        chk("R9 user reset reaches bus", (cw > 0) ? 1 : 0, 1);
        chk("R9 user reset width", cu, 4);
        standalone = 1'b0;
        settle();
    endtask

    task automatic t_por_midrun();
        int ce;
        #3 por_n = 1'b0;
        #1;
        chk("R1 async user", rst_user, 1);
        chk("R1 async bus", rst_bus, 1);
        chk("R1 async xcvr", rst_xcvr, 1);
        chk("R2 ext low in POR", rst_ext, 0);
        #30;
        @(negedge uclk) por_n = 1'b1;
        cnt_e(15, ce);
        chk("R2 ext after POR", ce, 0);
        settle();
    endtask

    initial begin
        t_power_on();
        t_short_hold();
        t_exact_hold();
        t_long_hold();
        t_node_hit();
        t_user_hit();
        t_retrigger();
        t_memory_bus();
        t_standalone();
        t_por_midrun();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule